// File: doc/BRIEF.md
# Interrupt Bank Context Stack

This block keeps the code-bank context of a processor that uses banked memory beyond its native address range. An 8-bit bank register holds two 4-bit fields: the bank that code runs from now and the bank chosen for the next far jump. Interrupts do not always start in the bank that was running. So on each interrupt entry the block saves that register to a small external byte-wide stack memory. It then switches both fields to an interrupt bank that software programmed beforehand. On return from the interrupt it restores the saved byte.

The CPU gives one-cycle strobes for interrupt entry and for return. A three-stage sequencer drives the stack memory through an 8-bit address bus, an 8-bit write-data bus, an 8-bit read-data bus and separate write and read strobes. The stack pointer is 8 bits wide. A push writes and then increments. A pop decrements and then reads. The pointer wraps modulo 256, and two sticky flags record a push at the top or a pop at the bottom. Software may write the bank register and the interrupt-bank field only while no sequence is running.

Top module: `bank_ctx_stack`

## Requirements
- R1: After reset, bank_o, sp_o, busy_o, ovf_o, unf_o, stk_wr_o and stk_rd_o are all zero.
- R2: An accepted entry strobe causes exactly one write-strobe cycle. It is the second cycle after the accepting edge. In that cycle stk_addr_o equals the stack pointer and stk_wdata_o equals the bank register as it stood before entry.
- R3: When a push completes, the stack pointer is one higher (modulo 256).
- R4: When a push completes, the bank register is {ib, ib}: bits 7:4 (next bank) and bits 3:0 (current bank) both equal the 4-bit interrupt-bank field ib.
- R5: An accepted return strobe first decrements the stack pointer. It then gives one read-strobe cycle with stk_addr_o equal to the decremented pointer. The bank register is loaded with stk_rdata_i as the memory presents it on the cycle after the read strobe.
- R6: busy_o is high for exactly three cycles after an accepted strobe. Entry or return strobes that arrive while busy_o is high have no effect.
- R7: If entry and return strobes arrive in the same idle cycle, only the entry (push) sequence runs.
- R8: A push with the pointer at 0xFF wraps it to 0x00 and sets ovf_o. ovf_o stays set until reset.
- R9: A pop with the pointer at 0x00 wraps it to 0xFF and sets unf_o. unf_o stays set until reset.
- R10: Software writes to the bank register and to the interrupt-bank field take effect on the next edge when no sequence is running. While busy_o is high they are ignored.
- R11: stk_wr_o and stk_rd_o are never high together, and neither is high while the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_enter_i | input | 1 | One-cycle interrupt-entry strobe |
| irq_return_i | input | 1 | One-cycle return-from-interrupt strobe |
| sw_bank_we_i | input | 1 | Software write enable for the bank register |
| sw_bank_wdata_i | input | 8 | Software data for the bank register |
| sw_ibank_we_i | input | 1 | Software write enable for the interrupt-bank field |
| sw_ibank_wdata_i | input | 4 | Software data for the interrupt-bank field |
| bank_o | output | 8 | Bank register {next bank, current bank} |
| ibank_o | output | 4 | Interrupt-bank field |
| sp_o | output | 8 | Stack pointer |
| busy_o | output | 1 | Sequence in progress |
| ovf_o | output | 1 | Sticky stack overflow |
| unf_o | output | 1 | Sticky stack underflow |
| stk_addr_o | output | 8 | Stack memory address |
| stk_wdata_o | output | 8 | Stack memory write data |
| stk_wr_o | output | 1 | Stack memory write strobe |
| stk_rd_o | output | 1 | Stack memory read strobe |
| stk_rdata_i | input | 8 | Stack memory read data, valid the cycle after stk_rd_o |

## Verification
The embedded assertions check several properties on every cycle. Read and write strobes are exclusive and appear only while busy. The sequence always returns to idle after its update stage. The pointer only ever moves by one. Both error flags stay set once raised. The bank register holds its value unless a load or an allowed software write occurs. Other behaviour depends on particular values and orderings, and only the directed scenarios can show it. These cover the exact address and data seen on the stack buses, the restored byte after nested entries and returns, entry winning a simultaneous strobe, strobes and software writes dropped while busy, and the wrap at both ends of the pointer.

// File: rtl/bank_ctx_pkg.sv
// Shared types for the interrupt bank context stack.
// Assumes: nothing beyond IEEE 1800-2017.
package bank_ctx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_DRIVE  = 2'd1,
        ST_ACCESS = 2'd2,
        ST_UPDATE = 2'd3
    } seq_state_e;

    typedef enum logic {
        OP_PUSH = 1'b0,
        OP_POP  = 1'b1
    } seq_op_e;

endpackage

// File: rtl/bank_ctx_seq.sv
// Sequencer: accepts entry/return strobes in idle and steps through
// DRIVE, ACCESS and UPDATE. It gives one-cycle control pulses to the
// pointer and register units and the memory strobes.
// Assumes: strobes are single-cycle; entry wins over return.
module bank_ctx_seq
    import bank_ctx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enter_i,
    input  logic return_i,
    output logic busy_o,
    output logic idle_o,
    output logic wr_o,
    output logic rd_o,
    output logic sp_inc_o,
    output logic sp_dec_o,
    output logic load_ib_o,
    output logic load_mem_o
);

    seq_state_e state_q, state_d;
    seq_op_e    op_q, op_d;

    // Next-state and operation selection.
    always_comb begin
        state_d = state_q;
        op_d    = op_q;
        unique case (state_q)
            ST_IDLE: begin
                if (enter_i) begin
                    state_d = ST_DRIVE;
                    op_d    = OP_PUSH;
                end else if (return_i) begin
                    state_d = ST_DRIVE;
                    op_d    = OP_POP;
                end
            end
            ST_DRIVE:  state_d = ST_ACCESS;
            ST_ACCESS: state_d = ST_UPDATE;
            ST_UPDATE: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State and operation registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            op_q    <= OP_PUSH;
        end else begin
            state_q <= state_d;
            op_q    <= op_d;
        end
    end

    // Decoded control pulses.
    always_comb begin
        idle_o     = (state_q == ST_IDLE);
        busy_o     = !idle_o;
        wr_o       = (state_q == ST_ACCESS) && (op_q == OP_PUSH);
        rd_o       = (state_q == ST_ACCESS) && (op_q == OP_POP);
        sp_dec_o   = (state_q == ST_DRIVE)  && (op_q == OP_POP);
        sp_inc_o   = (state_q == ST_UPDATE) && (op_q == OP_PUSH);
        load_ib_o  = (state_q == ST_UPDATE) && (op_q == OP_PUSH);
        load_mem_o = (state_q == ST_UPDATE) && (op_q == OP_POP);
    end

    // R11
    no_rdwr_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_o && rd_o));

    // R6
    seq_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_UPDATE) |=> (state_q == ST_IDLE));

    // R6
    seq_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && (enter_i || return_i)) |=> (state_q == ST_DRIVE));

    // R6
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DRIVE) |=> (state_q == ST_ACCESS));

endmodule

// File: rtl/bank_ctx_sp.sv
// Stack pointer: post-increment on push and pre-decrement on pop,
// wrapping modulo 2**SP_W, with sticky overflow and underflow flags.
// Assumes: inc and dec pulses never coincide.
module bank_ctx_sp #(
    parameter int SP_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            inc_i,
    input  logic            dec_i,
    output logic [SP_W-1:0] sp_o,
    output logic            ovf_o,
    output logic            unf_o
);

    localparam logic [SP_W-1:0] SP_TOP = {SP_W{1'b1}};
    localparam logic [SP_W-1:0] SP_BOT = '0;
    localparam logic [SP_W-1:0] SP_ONE = {{(SP_W-1){1'b0}}, 1'b1};

    logic [SP_W-1:0] sp_q;
    logic            ovf_q, unf_q;

    // Pointer update with wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp_q <= SP_BOT;
        end else if (inc_i) begin
            sp_q <= sp_q + SP_ONE;
        end else if (dec_i) begin
            sp_q <= sp_q - SP_ONE;
        end
    end

    // Sticky error flags, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_q <= 1'b0;
            unf_q <= 1'b0;
        end else begin
            if (inc_i && sp_q == SP_TOP) ovf_q <= 1'b1;
            if (dec_i && sp_q == SP_BOT) unf_q <= 1'b1;
        end
    end

    assign sp_o  = sp_q;
    assign ovf_o = ovf_q;
    assign unf_o = unf_q;

    // R3
    sp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sp_q) |-> (sp_q == $past(sp_q) + SP_ONE || sp_q == $past(sp_q) - SP_ONE));

    // R8
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_q |=> ovf_q);

    // R9
    unf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        unf_q |=> unf_q);

endmodule

// File: rtl/bank_ctx_regs.sv
// Bank register {next, current} and interrupt-bank field. It loads from
// the interrupt-bank field on push, from stack read data on pop, or
// from software while idle.
// Assumes: load pulses come only from the sequencer and never coincide.
module bank_ctx_regs #(
    parameter int FIELD_W = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sw_ok_i,
    input  logic                 sw_bank_we_i,
    input  logic [2*FIELD_W-1:0] sw_bank_wdata_i,
    input  logic                 sw_ibank_we_i,
    input  logic [FIELD_W-1:0]   sw_ibank_wdata_i,
    input  logic                 load_ib_i,
    input  logic                 load_mem_i,
    input  logic [2*FIELD_W-1:0] mem_rdata_i,
    output logic [2*FIELD_W-1:0] bank_o,
    output logic [FIELD_W-1:0]   ibank_o
);

    localparam int BANK_W = 2 * FIELD_W;

    logic [BANK_W-1:0]  bank_q;
    logic [FIELD_W-1:0] ib_q;
    logic               sw_bank_hit;

    assign sw_bank_hit = sw_ok_i && sw_bank_we_i;

    // Bank register: sequencer loads have priority over software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else if (load_ib_i) begin
            bank_q <= {ib_q, ib_q};
        end else if (load_mem_i) begin
            bank_q <= mem_rdata_i;
        end else if (sw_bank_hit) begin
            bank_q <= sw_bank_wdata_i;
        end
    end

    // Interrupt-bank field, written by software only while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ib_q <= '0;
        end else if (sw_ok_i && sw_ibank_we_i) begin
            ib_q <= sw_ibank_wdata_i;
        end
    end

    assign bank_o  = bank_q;
    assign ibank_o = ib_q;

    // R10
    bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_ib_i && !load_mem_i && !sw_bank_hit) |=> $stable(bank_q));

    // R10
    ib_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_ok_i |=> $stable(ib_q));

endmodule

// File: rtl/bank_ctx_stack.sv
// Top: saves the bank register to an external byte stack on interrupt
// entry and switches to the interrupt bank; restores it on return.
// Assumes: the stack memory writes on the strobe edge and returns read
// data registered on the cycle after stk_rd_o.
module bank_ctx_stack #(
    parameter int FIELD_W = 4,
    parameter int SP_W    = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 irq_enter_i,
    input  logic                 irq_return_i,
    input  logic                 sw_bank_we_i,
    input  logic [2*FIELD_W-1:0] sw_bank_wdata_i,
    input  logic                 sw_ibank_we_i,
    input  logic [FIELD_W-1:0]   sw_ibank_wdata_i,
    output logic [2*FIELD_W-1:0] bank_o,
    output logic [FIELD_W-1:0]   ibank_o,
    output logic [SP_W-1:0]      sp_o,
    output logic                 busy_o,
    output logic                 ovf_o,
    output logic                 unf_o,
    output logic [SP_W-1:0]      stk_addr_o,
    output logic [2*FIELD_W-1:0] stk_wdata_o,
    output logic                 stk_wr_o,
    output logic                 stk_rd_o,
    input  logic [2*FIELD_W-1:0] stk_rdata_i
);

    logic idle, sp_inc, sp_dec, load_ib, load_mem;

    bank_ctx_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .enter_i    (irq_enter_i),
        .return_i   (irq_return_i),
        .busy_o     (busy_o),
        .idle_o     (idle),
        .wr_o       (stk_wr_o),
        .rd_o       (stk_rd_o),
        .sp_inc_o   (sp_inc),
        .sp_dec_o   (sp_dec),
        .load_ib_o  (load_ib),
        .load_mem_o (load_mem)
    );

    bank_ctx_sp #(.SP_W(SP_W)) u_sp (
        .clk   (clk),
        .rst_n (rst_n),
        .inc_i (sp_inc),
        .dec_i (sp_dec),
        .sp_o  (sp_o),
        .ovf_o (ovf_o),
        .unf_o (unf_o)
    );

    bank_ctx_regs #(.FIELD_W(FIELD_W)) u_regs (
        .clk              (clk),
        .rst_n            (rst_n),
        .sw_ok_i          (idle),
        .sw_bank_we_i     (sw_bank_we_i),
        .sw_bank_wdata_i  (sw_bank_wdata_i),
        .sw_ibank_we_i    (sw_ibank_we_i),
        .sw_ibank_wdata_i (sw_ibank_wdata_i),
        .load_ib_i        (load_ib),
        .load_mem_i       (load_mem),
        .mem_rdata_i      (stk_rdata_i),
        .bank_o           (bank_o),
        .ibank_o          (ibank_o)
    );

    // Stack buses follow the pointer and bank register directly.
    assign stk_addr_o  = sp_o;
    assign stk_wdata_o = bank_o;

    // R11
    strobe_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stk_wr_o || stk_rd_o) |-> busy_o);

    // R2
    push_data_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stk_wr_o |-> $stable(stk_wdata_o));

endmodule

// File: tb/bank_ctx_stack_tb.sv
module bank_ctx_stack_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       irq_enter_i = 1'b0, irq_return_i = 1'b0;
    logic       sw_bank_we_i = 1'b0, sw_ibank_we_i = 1'b0;
    logic [7:0] sw_bank_wdata_i = '0;
    logic [3:0] sw_ibank_wdata_i = '0;
    logic [7:0] bank_o, sp_o, stk_addr_o, stk_wdata_o;
    logic [7:0] stk_rdata_i = '0;
    logic [3:0] ibank_o;
    logic       busy_o, ovf_o, unf_o, stk_wr_o, stk_rd_o;

    int n_chk = 0, n_bad = 0;
    logic [7:0] mem [256];
    int wr_cnt = 0, rd_cnt = 0, both_cnt = 0, idle_strobe_cnt = 0;
    logic [7:0] last_wa, last_wd, last_ra;
    int bcnt;

    always #10 clk = ~clk;

    bank_ctx_stack u_dut (.*);

    // Stack memory model: writes on the strobe edge, registered read data.
    always @(posedge clk) begin
        if (stk_wr_o) begin
            mem[stk_addr_o] <= stk_wdata_o;
            wr_cnt  <= wr_cnt + 1;
            last_wa <= stk_addr_o;
            last_wd <= stk_wdata_o;
        end
        if (stk_rd_o) begin
            stk_rdata_i <= mem[stk_addr_o];
            rd_cnt  <= rd_cnt + 1;
            last_ra <= stk_addr_o;
        end
        if (rst_n && stk_wr_o && stk_rd_o) both_cnt <= both_cnt + 1;
        if (rst_n && !busy_o && (stk_wr_o || stk_rd_o)) idle_strobe_cnt <= idle_strobe_cnt + 1;
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Drive one strobe pattern for one cycle, then count busy cycles.
    task automatic strobe(input logic en, input logic rt);
        @(negedge clk);
        irq_enter_i = en; irq_return_i = rt;
        @(negedge clk);
        irq_enter_i = 0; irq_return_i = 0;
        bcnt = 0;
        for (int i = 0; i < 4; i++) begin
            if (busy_o) bcnt++;
            @(negedge clk);
        end
    endtask

    task automatic sw_write(input logic wb, input logic [7:0] b, input logic wi, input logic [3:0] ib);
        @(negedge clk);
        sw_bank_we_i = wb; sw_bank_wdata_i = b; sw_ibank_we_i = wi; sw_ibank_wdata_i = ib;
        @(negedge clk);
        sw_bank_we_i = 0; sw_ibank_we_i = 0;
    endtask

    task automatic t_reset;
        chk("R1 bank", bank_o, 0);
        chk("R1 sp", sp_o, 0);
        chk("R1 busy", busy_o, 0);
        chk("R1 flags", {ovf_o, unf_o}, 0);
        chk("R1 strobes", {stk_wr_o, stk_rd_o}, 0);
    endtask

    task automatic t_push_pop_nested;
        int w0;
        sw_write(1, 8'h3C, 1, 4'h7);
        chk("R10 sw bank idle", bank_o, 8'h3C);
        chk("R10 sw ibank idle", ibank_o, 4'h7);
        w0 = wr_cnt;
        strobe(1, 0);
        chk("R2 one write", wr_cnt - w0, 1);
        chk("R2 write addr", last_wa, 8'h00);
        chk("R2 write data", last_wd, 8'h3C);
        chk("R3 sp after push", sp_o, 8'h01);
        chk("R4 bank after push", bank_o, 8'h77);
        chk("R6 busy length", bcnt, 3);
        sw_write(0, 0, 1, 4'h2);
        strobe(1, 0);
        chk("R2 nested addr", last_wa, 8'h01);
        chk("R2 nested data", last_wd, 8'h77);
        chk("R4 nested bank", bank_o, 8'h22);
        strobe(0, 1);
        chk("R5 pop addr", last_ra, 8'h01);
        chk("R5 pop bank", bank_o, 8'h77);
        chk("R5 pop sp", sp_o, 8'h01);
        chk("R6 busy length pop", bcnt, 3);
        strobe(0, 1);
        chk("R5 pop2 addr", last_ra, 8'h00);
        chk("R5 pop2 bank", bank_o, 8'h3C);
        chk("R5 pop2 sp", sp_o, 8'h00);
    endtask

    // Strobes during busy must not start another sequence.
    task automatic t_busy_ignore;
        int w0, r0;
        w0 = wr_cnt; r0 = rd_cnt;
        @(negedge clk); irq_enter_i = 1;
        @(negedge clk); irq_enter_i = 0; irq_return_i = 1;
        @(negedge clk); irq_return_i = 0; irq_enter_i = 1;
        @(negedge clk); irq_enter_i = 0;
        repeat (4) @(negedge clk);
        chk("R6 ignored sp", sp_o, 8'h01);
        chk("R6 ignored writes", wr_cnt - w0, 1);
        chk("R6 ignored reads", rd_cnt - r0, 0);
        chk("R6 idle after", busy_o, 0);
        strobe(0, 1);
        chk("R6 restore sp", sp_o, 8'h00);
        chk("R6 restore bank", bank_o, 8'h3C);
    endtask

    task automatic t_simultaneous;
        int w0, r0;
        w0 = wr_cnt; r0 = rd_cnt;
        strobe(1, 1);
        chk("R7 push wins writes", wr_cnt - w0, 1);
        chk("R7 push wins reads", rd_cnt - r0, 0);
        chk("R7 push wins sp", sp_o, 8'h01);
        strobe(0, 1);
    endtask

    // Software writes during a running sequence are dropped.
    task automatic t_sw_busy;
        @(negedge clk); irq_enter_i = 1;
        @(negedge clk); irq_enter_i = 0;
        sw_bank_we_i = 1; sw_bank_wdata_i = 8'hAA; sw_ibank_we_i = 1; sw_ibank_wdata_i = 4'h9;
        @(negedge clk); sw_bank_we_i = 0; sw_ibank_we_i = 0;
        repeat (3) @(negedge clk);
        chk("R10 busy bank write dropped", bank_o, 8'h22);
        chk("R10 busy ibank write dropped", ibank_o, 4'h2);
        strobe(0, 1);
        chk("R10 restore", bank_o, 8'h3C);
    endtask

    task automatic t_wrap;
        chk("R9 sp before", sp_o, 8'h00);
        strobe(0, 1);
        chk("R9 sp wrap", sp_o, 8'hFF);
        chk("R9 unf set", unf_o, 1);
        chk("R9 read addr", last_ra, 8'hFF);
        chk("R5 wrap data", bank_o, 8'hFF ^ 8'hA5);
        chk("R8 ovf clear", ovf_o, 0);
        strobe(1, 0);
        chk("R8 sp wrap", sp_o, 8'h00);
        chk("R8 ovf set", ovf_o, 1);
        chk("R8 write addr", last_wa, 8'hFF);
        strobe(1, 0);
        chk("R8 ovf sticky", ovf_o, 1);
        chk("R9 unf sticky", unf_o, 1);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'hA5;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_push_pop_nested();
        t_busy_ignore();
        t_simultaneous();
        t_sw_busy();
        t_wrap();
        chk("R11 rd/wr overlap", both_cnt, 0);
        chk("R11 strobe while idle", idle_strobe_cnt, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule